// File: doc/BRIEF.md
# Modem Status Register with Change Tracking

This block keeps the status half of a serial port's modem handshake. Four asynchronous modem input lines (clear-to-send, data-set-ready, ring indicator and carrier detect) pass through synchronisers. They are sampled into the upper nibble of an 8-bit status register. The lower nibble holds sticky change flags, one for each line. A read strobe returns the register and clears the change flags on the same clock edge. The OR of the flags goes to the interrupt logic as a change request.

The block also holds the 5-bit modem control register. When its loop bit is set, a status read shows the control outputs in place of the external lines, and the change flags are left untouched. After reset a small state machine runs. It has two states, ST_SETTLE and ST_TRACK. It stays in ST_SETTLE for SYNC_STAGES+1 cycles while the synchronisers fill, so the reset values of the flops cannot raise false changes. It then takes the transition ST_SETTLE -> ST_TRACK and stays in ST_TRACK until the next reset. Change flags are recorded only in ST_TRACK.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, with CTS, DSR and DCD inputs high and RI low, msr_rdata reads 0xB0, mcr_rdata reads 0x08 (OUT2 set) and ms_change_req is 0.
- R2: Status bit positions are DCD = bit 7, RI = bit 6, DSR = bit 5, CTS = bit 4. A level change on an input shows in msr_rdata on the third rising clock edge after it (SYNC_STAGES+1 edges at the default of 2), and not on the second.
- R3: Change flags DCTS (bit 0), DDSR (bit 1) and DDCD (bit 3) are set when their line changes in either direction. They stay set until a clearing read.
- R4: The trailing-edge ring flag (bit 2) is set only when RI goes from 1 to 0. A rise of RI leaves it at 0.
- R5: A read with the loop bit clear returns the current value, including the flags. At that edge it clears bits 3:0 and leaves bits 7:4 as they are.
- R6: A line change that lands on the same edge as a clearing read is kept. Its flag reads 1 after the read.
- R7: ms_change_req is the OR of the four change flags. It falls on the edge of a clearing read when no new change arrives.
- R8: The modem control register keeps write bits 4:0 (DTR 0, RTS 1, OUT1 2, OUT2 3, LOOP 4). Bits 7:5 of a write are ignored and read back as 0.
- R9: With LOOP set, msr_rdata[7:4] = {OUT2, OUT1, DTR, RTS} and msr_rdata[3:0] = 0. A read in this mode does not clear the flags, which read back unchanged once LOOP is cleared.
- R10: Input levels that differ from the reset values of the synchronisers when reset is released set no change flag. The status bits take the real levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| mcr_we | input | 1 | Write strobe for the modem control register |
| mcr_wdata | input | 8 | Modem control write data |
| mcr_rdata | output | 8 | Modem control register value, bits 7:5 zero |
| msr_rd | input | 1 | Status read strobe, one cycle per read |
| msr_rdata | output | 8 | Status register value, or the loopback view |
| ms_change_req | output | 1 | Modem status change request to the interrupt logic |

## Verification
Each line is toggled on its own, in both directions, so that a wrong bit position or a swapped flag shows up. The ring line is raised and dropped separately to separate the trailing-edge rule from the plain change rule. Several changes are stacked without reads to show that the flags are sticky. A read is also timed to meet a change on the same edge, to show whether set wins over clear. Loopback is tried with two complementary control patterns, which expose the cross mapping of DTR to DSR and RTS to CTS. Reset is also applied with lines away from their default levels, to show that the settle window suppresses false flags.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NUM_LINES = 4;
    localparam int REG_W     = 8;
    localparam int MCR_W     = 5;

    // line index inside the status nibble; msr bit = index + 4, flag bit = index
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    // modem control bit positions
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OUT1 = 2;
    localparam int MC_OUT2 = 3;
    localparam int MC_LOOP = 4;

    localparam logic [MCR_W-1:0]     MCR_RESET  = 5'b01000;
    localparam logic [NUM_LINES-1:0] LINE_RESET = 4'b1011;

    typedef enum logic [0:0] {
        ST_SETTLE = 1'b0,
        ST_TRACK  = 1'b1
    } track_state_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int               STAGES    = 2,
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RESET_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/msr_delta_track.sv
module msr_delta_track
    import msr_pkg::*;
#(
    parameter int                   SETTLE_CYCLES = 3,
    parameter logic [NUM_LINES-1:0] RESET_VAL     = LINE_RESET
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_sync,
    input  logic                 clear_req,
    output logic [NUM_LINES-1:0] line_q,
    output logic [NUM_LINES-1:0] delta_q
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    track_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] delta_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE: if (cnt_q == CNT_LAST) state_d = ST_TRACK;
            ST_TRACK:  state_d = ST_TRACK;
            default:   state_d = ST_SETTLE;
        endcase
    end

    // per-line flag set condition
    for (genvar b = 0; b < NUM_LINES; b++) begin : g_set
        if (b == IDX_RI) begin : g_trail
            assign set_vec[b] = line_q[b] & ~line_sync[b];
        end else begin : g_any
            assign set_vec[b] = line_q[b] ^ line_sync[b];
        end
    end

    // outputs
    always_comb begin
        delta_d = clear_req ? '0 : delta_q;
        unique case (state_q)
            ST_SETTLE: delta_d = delta_d;
            ST_TRACK:  delta_d = delta_d | set_vec;
            default:   delta_d = delta_d;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= RESET_VAL;
            delta_q <= '0;
        end else begin
            line_q  <= line_sync;
            delta_q <= delta_d;
        end
    end
endmodule

// File: rtl/msr_ctrl_reg.sv
module msr_ctrl_reg
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [MCR_W-1:0] mcr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcr_q <= MCR_RESET;
        end else if (we) begin
            mcr_q <= wdata[MCR_W-1:0];
        end
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       ri_in,
    input  logic       dcd_in,
    input  logic       mcr_we,
    input  logic [7:0] mcr_wdata,
    output logic [7:0] mcr_rdata,
    input  logic       msr_rd,
    output logic [7:0] msr_rdata,
    output logic       ms_change_req
);
    localparam int SETTLE_CYCLES = SYNC_STAGES + 1;

    logic [NUM_LINES-1:0] line_raw;
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] line_q;
    logic [NUM_LINES-1:0] delta_q;
    logic [NUM_LINES-1:0] loop_view;
    logic [MCR_W-1:0]     mcr_q;
    logic                 loop_on;
    logic                 clear_req;

    always_comb begin
        line_raw          = '0;
        line_raw[IDX_CTS] = cts_in;
        line_raw[IDX_DSR] = dsr_in;
        line_raw[IDX_RI]  = ri_in;
        line_raw[IDX_DCD] = dcd_in;
    end

    msr_sync #(
        .STAGES    (SYNC_STAGES),
        .WIDTH     (NUM_LINES),
        .RESET_VAL (LINE_RESET)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_raw),
        .dout  (line_sync)
    );

    msr_ctrl_reg u_mcr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mcr_we),
        .wdata (mcr_wdata),
        .mcr_q (mcr_q)
    );

    assign loop_on   = mcr_q[MC_LOOP];
    assign clear_req = msr_rd & ~loop_on;

    msr_delta_track #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .RESET_VAL     (LINE_RESET)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .clear_req (clear_req),
        .line_q    (line_q),
        .delta_q   (delta_q)
    );

    always_comb begin
        loop_view          = '0;
        loop_view[IDX_DCD] = mcr_q[MC_OUT2];
        loop_view[IDX_RI]  = mcr_q[MC_OUT1];
        loop_view[IDX_DSR] = mcr_q[MC_DTR];
        loop_view[IDX_CTS] = mcr_q[MC_RTS];
    end

    assign msr_rdata     = loop_on ? {loop_view, 4'h0} : {line_q, delta_q};
    assign mcr_rdata     = {{(REG_W-MCR_W){1'b0}}, mcr_q};
    assign ms_change_req = |delta_q;
endmodule

// File: rtl/modem_status_unit_chk.sv
module modem_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       msr_rd,
    input logic [7:0] msr_rdata,
    input logic [7:0] mcr_rdata,
    input logic       ms_change_req,
    input logic [3:0] line_sync,
    input logic [3:0] line_q,
    input logic [3:0] delta_q
);
    p_status_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_rdata[4] |-> msr_rdata[7:4] == line_q);

    p_flags_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(msr_rd && !mcr_rdata[4]) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    p_trailing_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(line_q[2]) && !line_q[2]));

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !mcr_rdata[4] && line_sync == line_q) |=> delta_q == 4'h0);

    p_request_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_rdata[4] |-> ms_change_req == (msr_rdata[3:0] != 4'h0));

    p_mcr_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[7:5] == 3'b000);

    p_loop_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[4] |-> msr_rdata[3:0] == 4'h0);

    p_loop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && mcr_rdata[4]) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
endmodule

bind modem_status_unit modem_status_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msr_rd        (msr_rd),
    .msr_rdata     (msr_rdata),
    .mcr_rdata     (mcr_rdata),
    .ms_change_req (ms_change_req),
    .line_sync     (line_sync),
    .line_q        (line_q),
    .delta_q       (delta_q)
);

// File: tb/modem_status_unit_bench.sv
`timescale 1ns/1ps
module modem_status_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_in = 1'b1, dsr_in = 1'b1, ri_in = 1'b0, dcd_in = 1'b1;
    logic       mcr_we = 1'b0;
    logic [7:0] mcr_wdata = 8'h00;
    logic [7:0] mcr_rdata;
    logic       msr_rd = 1'b0;
    logic [7:0] msr_rdata;
    logic       ms_change_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    modem_status_unit u_modem_status_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .cts_in        (cts_in),
        .dsr_in        (dsr_in),
        .ri_in         (ri_in),
        .dcd_in        (dcd_in),
        .mcr_we        (mcr_we),
        .mcr_wdata     (mcr_wdata),
        .mcr_rdata     (mcr_rdata),
        .msr_rd        (msr_rd),
        .msr_rdata     (msr_rdata),
        .ms_change_req (ms_change_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] val);
        msr_rd = 1'b1;
        #1 val = msr_rdata;
        tick(1);
        msr_rd = 1'b0;
        #1;
    endtask

    task automatic write_mcr(input logic [7:0] v);
        mcr_we = 1'b1;
        mcr_wdata = v;
        tick(1);
        mcr_we = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(6);
    endtask

    task automatic t_reset();
        apply_reset();
        check("R1", "status after reset", msr_rdata, 8'hB0);
        check("R1", "control after reset", mcr_rdata, 8'h08);
        check("R1", "request after reset", {7'b0, ms_change_req}, 8'h00);
    endtask

    task automatic t_latency_and_clear();
        logic [7:0] v;
        cts_in = 1'b0;
        tick(2);
        check("R2", "CTS not yet visible after two edges", msr_rdata, 8'hB0);
        tick(1);
        check("R2", "CTS low on bit 4 with DCTS", msr_rdata, 8'hA1);
        check("R7", "request raised by DCTS", {7'b0, ms_change_req}, 8'h01);
        do_read(v);
        check("R5", "read returns flags", v, 8'hA1);
        check("R5", "flags cleared after read", msr_rdata, 8'hA0);
        check("R7", "request dropped after read", {7'b0, ms_change_req}, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        cts_in = 1'b1; tick(4);
        check("R3", "CTS rise sets DCTS", msr_rdata, 8'hB1);
        dsr_in = 1'b0; tick(4);
        check("R3", "DSR fall sets DDSR, DCTS kept", msr_rdata, 8'h93);
        tick(5);
        check("R3", "flags held without read", msr_rdata, 8'h93);
        dsr_in = 1'b1; tick(4);
        check("R3", "DSR rise keeps flags", msr_rdata, 8'hB3);
        do_read(v);
        check("R5", "clear leaves status bits", msr_rdata, 8'hB0);
        dcd_in = 1'b0; tick(4);
        check("R3", "DCD fall on bit 7 with DDCD", msr_rdata, 8'h38);
        dcd_in = 1'b1; tick(4);
        check("R3", "DCD rise keeps DDCD", msr_rdata, 8'hB8);
        do_read(v);
        check("R5", "clear after DCD", msr_rdata, 8'hB0);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        ri_in = 1'b1; tick(4);
        check("R4", "RI rise sets no trailing flag", msr_rdata, 8'hF0);
        check("R7", "no request on RI rise", {7'b0, ms_change_req}, 8'h00);
        ri_in = 1'b0; tick(4);
        check("R4", "RI fall sets trailing flag", msr_rdata, 8'hB4);
        check("R7", "request on trailing ring", {7'b0, ms_change_req}, 8'h01);
        do_read(v);
        check("R5", "clear after ring", msr_rdata, 8'hB0);
    endtask

    task automatic t_coincide();
        logic [7:0] v;
        dcd_in = 1'b0; tick(4);
        check("R6", "DCD flag before collision", msr_rdata, 8'h38);
        cts_in = 1'b0;
        tick(2);
        do_read(v);
        check("R6", "read value before collision edge", v, 8'h38);
        check("R6", "change on read edge kept", msr_rdata, 8'h21);
        dcd_in = 1'b1; cts_in = 1'b1; tick(4);
        check("R6", "restored lines", msr_rdata, 8'hB9);
        do_read(v);
        check("R5", "clear after collision", msr_rdata, 8'hB0);
    endtask

    task automatic t_mcr();
        write_mcr(8'hE3);
        check("R8", "upper write bits dropped", mcr_rdata, 8'h03);
        write_mcr(8'h08);
        check("R8", "control restored", mcr_rdata, 8'h08);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        cts_in = 1'b0; tick(4);
        check("R9", "flag before loop", msr_rdata, 8'hA1);
        write_mcr(8'h19);
        check("R9", "loop view OUT2 and DTR", msr_rdata, 8'hA0);
        do_read(v);
        check("R9", "loop read value", v, 8'hA0);
        write_mcr(8'h16);
        check("R9", "loop view OUT1 and RTS", msr_rdata, 8'h50);
        do_read(v);
        write_mcr(8'h08);
        check("R9", "flags kept after loop reads", msr_rdata, 8'hA1);
        check("R7", "request kept after loop reads", {7'b0, ms_change_req}, 8'h01);
        do_read(v);
        cts_in = 1'b1; tick(4);
        do_read(v);
        check("R5", "clean after loop", msr_rdata, 8'hB0);
    endtask

    task automatic t_settle();
        logic [7:0] v;
        cts_in = 1'b0; dsr_in = 1'b0;
        apply_reset();
        check("R10", "off-default lines at reset set no flag", msr_rdata, 8'h80);
        check("R10", "no request after settle", {7'b0, ms_change_req}, 8'h00);
        cts_in = 1'b1; dsr_in = 1'b1; tick(4);
        check("R3", "changes after settle recorded", msr_rdata, 8'hB3);
        do_read(v);
    endtask

    initial begin
        t_reset();
        t_latency_and_clear();
        t_sticky();
        t_ring();
        t_coincide();
        t_mcr();
        t_loop();
        t_settle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule